// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits on the controller side of a DDR3-class memory interface. It moves the SDRAM into self-refresh when the system asks it to sleep, and brings it back when the system asks it to wake. It meets every entry precondition and exit delay on the way. While it owns the command bus it drives the chip-select, row-strobe, column-strobe and write-enable lines, the A10 bit, the clock-enable pin and on-die termination. It also tells the clock generator when the memory clock may be stopped, and it waits for a clock-stable indication before the exit.

Every delay is a cycle count taken from configuration inputs. One down-counter serves all the waits and is reloaded at each state change. A delay of n waits max(n,1) cycles, written W(n) below. Two flags tell the read/write scheduler what it may issue again: `nondll_ok` covers commands that do not need a locked DLL, and `dll_ok` covers all commands. While `bus_own` is high the scheduler must stall, and an external mux selects this block's command lines. The clock generator may stop the memory clock only while `clk_stop_ok` is high. It raises `clk_stable` once the clock runs steadily again.

Top module: `srf_seq`

## Requirements
- R1: After reset the block is idle: `cke`=1, `bus_own`=0, `clk_stop_ok`=0, `nondll_ok`=`dll_ok`=1, the command lines show NOP, and `odt` follows `sys_odt`.
- R2: Command lines {cs_n,ras_n,cas_n,we_n} encode NOP=0111, precharge-all=0010 with `cmd_a10`=1, refresh=0001 with `cke`=1, and self-refresh entry=0001 with `cke`=0. From the cycle after `sleep_req` is sampled in idle, `bus_own`=1 and both ok flags are 0.
- R3: `odt` is 0 from the first owned cycle onward. The first non-NOP command appears W(`cfg_odt_lead`) cycles after that cycle.
- R4: When `banks_open`=1 the first command is a precharge-all, and the next command follows W(`cfg_trp`)+1 cycles later. When `banks_open`=0 no precharge is issued.
- R5: Every entry after a completed exit issues one refresh, and the entry command follows W(`cfg_trfc`)+1 cycles later. The first entry after reset issues no refresh.
- R6: The entry command is followed in the next cycle by exactly one NOP with `cke`=0. `cke` stays 0 until the exit.
- R7: `clk_stop_ok` rises W(`cfg_tcksre`)+1 cycles after the entry command. It is high only while `cke`=0, and it falls when the exit begins.
- R8: The exit never begins earlier than W(`cfg_tcksre`)+W(max(`cfg_tckesr`-`cfg_tcksre`,0))+2 cycles after the entry command. A wake request that arrives during entry is latched and serviced at that point. `cke` is low for at least `cfg_tckesr` cycles.
- R9: While the device sleeps, a `sleep_req` pulse has no effect, and in idle a `wake_req` pulse has no effect.
- R10: `cke` rises W(`cfg_tcksrx`)+1 cycles after the first cycle in which `clk_stable` is sampled high after the exit began. A cycle with `clk_stable` low restarts that wait.
- R11: The cycle in which `cke` rises carries a NOP. For W(`cfg_txs`) cycles from then on, only NOP appears, `bus_own`=1 and `odt`=0. After that `nondll_ok` rises.
- R12: `dll_ok` rises W(max(`cfg_txsdll`-`cfg_txs`,0)) cycles after `nondll_ok`. Until then `odt`=0 and `cke`=1.
- R13: A `sleep_req` during the window in which non-DLL commands are allowed but DLL ones are not starts a new entry at once, and that entry includes the refresh of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| banks_open | input | 1 | Some bank may be open; a precharge-all is needed |
| sys_odt | input | 1 | Scheduler's termination request, passed through when idle |
| clk_stable | input | 1 | Clock generator reports a steady memory clock |
| cfg_odt_lead | input | CW | Cycles of termination off before the first entry command |
| cfg_trp | input | CW | Precharge-to-command delay |
| cfg_trfc | input | CW | Refresh-to-command delay |
| cfg_tcksre | input | CW | Cycles the clock must still run after entry |
| cfg_tckesr | input | CW | Minimum self-refresh residency |
| cfg_tcksrx | input | CW | Stable clock cycles required before exit |
| cfg_txs | input | CW | Exit delay for commands without a locked DLL |
| cfg_txsdll | input | CW | Exit delay for commands needing a locked DLL |
| bus_own | output | 1 | Block drives the command bus; scheduler stalls |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10, high for precharge-all |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination |
| clk_stop_ok | output | 1 | Memory clock may be stopped or changed |
| nondll_ok | output | 1 | Commands without a locked DLL are allowed |
| dll_ok | output | 1 | All commands are allowed |

## Verification
The bound checker watches the pin-level rules on every cycle. An entry command must be followed by a NOP with `cke` low. Termination must be off whenever `cke` is low. A clock stop must never be permitted while `cke` is high. The exit must carry a NOP. Residency and the exit delay are measured with counters, and `dll_ok` may never come up ahead of `nondll_ok`. The exact cycle positions of each command are left to the bench's swept scenarios. So are the choice between precharge and refresh, the latching of an early wake, the restart of the stable-clock wait after a glitch, and re-entry from inside the DLL window.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ODT,
    ST_PREA,
    ST_RP,
    ST_REF,
    ST_RFC,
    ST_SELF,
    ST_CKSRE,
    ST_RESID,
    ST_SLEEP,
    ST_CLKREQ,
    ST_CKSRX,
    ST_XS,
    ST_XSDLL
  } srf_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } srf_cmd_t;

  localparam srf_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam srf_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam srf_cmd_t CMD_REFS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/srf_rst_sync.sv
module srf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];

endmodule

// File: rtl/srf_timer.sv
module srf_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // a wait of n lasts max(n,1) cycles: done when the count is one or zero
  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q <= CW'(1));

endmodule

// File: rtl/srf_fsm.sv
module srf_fsm
  import srf_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          banks_open,
  input  logic          clk_stable,
  input  logic          tmr_done,
  input  logic [CW-1:0] cfg_odt_lead,
  input  logic [CW-1:0] cfg_trp,
  input  logic [CW-1:0] cfg_trfc,
  input  logic [CW-1:0] cfg_tcksre,
  input  logic [CW-1:0] cfg_tckesr,
  input  logic [CW-1:0] cfg_tcksrx,
  input  logic [CW-1:0] cfg_txs,
  input  logic [CW-1:0] cfg_txsdll,
  output srf_state_t    state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  srf_state_t state_q, state_d;
  logic       wake_pend_q, wake_pend_d;
  logic       need_ref_q, need_ref_d;
  logic [CW-1:0] resid_rem, dll_rem;
  logic       in_entry;

  // residency left after the clock-run window, and DLL window past tXS
  assign resid_rem = (cfg_tckesr > cfg_tcksre) ? cfg_tckesr - cfg_tcksre : '0;
  assign dll_rem   = (cfg_txsdll > cfg_txs)    ? cfg_txsdll - cfg_txs    : '0;

  assign in_entry = (state_q == ST_ODT)   || (state_q == ST_PREA)  ||
                    (state_q == ST_RP)    || (state_q == ST_REF)   ||
                    (state_q == ST_RFC)   || (state_q == ST_SELF)  ||
                    (state_q == ST_CKSRE) || (state_q == ST_RESID) ||
                    (state_q == ST_SLEEP);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (sleep_req) begin
        state_d = ST_ODT; tmr_load = 1'b1; tmr_val = cfg_odt_lead;
      end
      ST_ODT: if (tmr_done) begin
        if (banks_open)      state_d = ST_PREA;
        else if (need_ref_q) state_d = ST_REF;
        else                 state_d = ST_SELF;
      end
      ST_PREA: begin
        state_d = ST_RP; tmr_load = 1'b1; tmr_val = cfg_trp;
      end
      ST_RP: if (tmr_done) state_d = need_ref_q ? ST_REF : ST_SELF;
      ST_REF: begin
        state_d = ST_RFC; tmr_load = 1'b1; tmr_val = cfg_trfc;
      end
      ST_RFC: if (tmr_done) state_d = ST_SELF;
      ST_SELF: begin
        state_d = ST_CKSRE; tmr_load = 1'b1; tmr_val = cfg_tcksre;
      end
      ST_CKSRE: if (tmr_done) begin
        state_d = ST_RESID; tmr_load = 1'b1; tmr_val = resid_rem;
      end
      ST_RESID: if (tmr_done) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_pend_q || wake_req) state_d = ST_CLKREQ;
      ST_CLKREQ: if (clk_stable) begin
        state_d = ST_CKSRX; tmr_load = 1'b1; tmr_val = cfg_tcksrx;
      end
      ST_CKSRX: begin
        if (!clk_stable) state_d = ST_CLKREQ;
        else if (tmr_done) begin
          state_d = ST_XS; tmr_load = 1'b1; tmr_val = cfg_txs;
        end
      end
      ST_XS: if (tmr_done) begin
        state_d = ST_XSDLL; tmr_load = 1'b1; tmr_val = dll_rem;
      end
      ST_XSDLL: begin
        if (sleep_req) begin
          state_d = ST_ODT; tmr_load = 1'b1; tmr_val = cfg_odt_lead;
        end else if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wake_pend_d = in_entry && (state_q != ST_SLEEP) && (wake_pend_q || wake_req);
    need_ref_d  = need_ref_q;
    if (state_q == ST_XS)  need_ref_d = 1'b1;
    if (state_q == ST_REF) need_ref_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wake_pend_q <= 1'b0;
      need_ref_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= wake_pend_d;
      need_ref_q  <= need_ref_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/srf_outdec.sv
module srf_outdec
  import srf_pkg::*;
(
  input  srf_state_t state,
  input  logic       sys_odt,
  output logic       bus_own,
  output srf_cmd_t   cmd,
  output logic       cmd_a10,
  output logic       cke,
  output logic       odt,
  output logic       clk_stop_ok,
  output logic       nondll_ok,
  output logic       dll_ok
);

  always_comb begin
    cmd         = CMD_NOP;
    cmd_a10     = 1'b0;
    cke         = 1'b1;
    clk_stop_ok = 1'b0;
    unique case (state)
      ST_PREA:  begin cmd = CMD_PREA; cmd_a10 = 1'b1; end
      ST_REF:   cmd = CMD_REFS;
      ST_SELF:  begin cmd = CMD_REFS; cke = 1'b0; end
      ST_CKSRE, ST_CLKREQ, ST_CKSRX: cke = 1'b0;
      ST_RESID, ST_SLEEP: begin cke = 1'b0; clk_stop_ok = 1'b1; end
      default: ;
    endcase
    nondll_ok = (state == ST_IDLE) || (state == ST_XSDLL);
    dll_ok    = (state == ST_IDLE);
    bus_own   = !nondll_ok;
    odt       = (state == ST_IDLE) ? sys_odt : 1'b0;
  end

endmodule

// File: rtl/srf_seq.sv
module srf_seq
  import srf_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          banks_open,
  input  logic          sys_odt,
  input  logic          clk_stable,
  input  logic [CW-1:0] cfg_odt_lead,
  input  logic [CW-1:0] cfg_trp,
  input  logic [CW-1:0] cfg_trfc,
  input  logic [CW-1:0] cfg_tcksre,
  input  logic [CW-1:0] cfg_tckesr,
  input  logic [CW-1:0] cfg_tcksrx,
  input  logic [CW-1:0] cfg_txs,
  input  logic [CW-1:0] cfg_txsdll,
  output logic          bus_own,
  output logic          cmd_cs_n,
  output logic          cmd_ras_n,
  output logic          cmd_cas_n,
  output logic          cmd_we_n,
  output logic          cmd_a10,
  output logic          cke,
  output logic          odt,
  output logic          clk_stop_ok,
  output logic          nondll_ok,
  output logic          dll_ok
);

  logic          rst_sync_n;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  srf_state_t    state;
  srf_cmd_t      cmd;

  srf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  srf_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  srf_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .sleep_req(sleep_req), .wake_req(wake_req), .banks_open(banks_open),
    .clk_stable(clk_stable), .tmr_done(tmr_done),
    .cfg_odt_lead(cfg_odt_lead), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
    .cfg_tcksre(cfg_tcksre), .cfg_tckesr(cfg_tckesr), .cfg_tcksrx(cfg_tcksrx),
    .cfg_txs(cfg_txs), .cfg_txsdll(cfg_txsdll),
    .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  srf_outdec u_dec (
    .state(state), .sys_odt(sys_odt), .bus_own(bus_own), .cmd(cmd),
    .cmd_a10(cmd_a10), .cke(cke), .odt(odt), .clk_stop_ok(clk_stop_ok),
    .nondll_ok(nondll_ok), .dll_ok(dll_ok)
  );

  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;

endmodule

// File: rtl/srf_seq_chk.sv
module srf_seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_own,
  input logic          cmd_cs_n,
  input logic          cmd_ras_n,
  input logic          cmd_cas_n,
  input logic          cmd_we_n,
  input logic          cke,
  input logic          odt,
  input logic          clk_stop_ok,
  input logic          nondll_ok,
  input logic          dll_ok,
  input logic [CW-1:0] cfg_tckesr,
  input logic [CW-1:0] cfg_txs
);

  logic          is_nop, is_self;
  logic [CW:0]   low_age, high_age;
  localparam logic [CW:0] AGE_MAX = '1;

  assign is_nop  = !cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n;
  assign is_self = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n && !cke;

  // cycles cke has been low / high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_age  <= '0;
      high_age <= AGE_MAX;
    end else begin
      low_age  <= cke ? '0 : ((low_age == AGE_MAX) ? low_age : low_age + 1'b1);
      high_age <= !cke ? '0 : ((high_age == AGE_MAX) ? high_age : high_age + 1'b1);
    end
  end

  p_self_then_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_self |=> (is_nop && !cke));

  p_odt_off_asleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !odt);

  p_stop_only_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_ok |-> !cke);

  p_exit_is_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (is_nop && bus_own && !nondll_ok));

  p_residency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_age >= {1'b0, cfg_tckesr}));

  p_xs_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nondll_ok) |-> (high_age >= {1'b0, cfg_txs}));

  p_dll_after_nondll_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dll_ok |-> (nondll_ok && cke));

endmodule

bind srf_seq srf_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_own(bus_own),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
  .cke(cke), .odt(odt), .clk_stop_ok(clk_stop_ok), .nondll_ok(nondll_ok), .dll_ok(dll_ok),
  .cfg_tckesr(cfg_tckesr), .cfg_txs(cfg_txs)
);

// File: tb/sim_srf_seq.sv
`timescale 1ns/1ps
module sim_srf_seq;

  localparam int CW = 8;

  logic clk, rst_n;
  logic sleep_req, wake_req, banks_open, sys_odt, clk_stable;
  logic [CW-1:0] cfg_odt_lead, cfg_trp, cfg_trfc, cfg_tcksre, cfg_tckesr;
  logic [CW-1:0] cfg_tcksrx, cfg_txs, cfg_txsdll;
  logic bus_own, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;
  logic cke, odt, clk_stop_ok, nondll_ok, dll_ok;

  int n_run, n_fail;
  bit had_exit;

  srf_seq #(.CW(CW)) u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int w(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  function automatic int sat(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic logic [3:0] cmdv();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  // caller is at a negedge; one full sleep/wake round trip
  task automatic do_run(input int lead, input bit banks, input int sre, input int esr,
                        input bit late, input int srx, input int dly, input bit glitch,
                        input int txs, input int txsdll, input bit quick);
    int ts = -1, tp = -1, tr = -1, tf = -1, tcs = -1, q = -1, k = -1, n = -1, d = -1;
    int w_at = -1, stab_at = -1, bad_sr = 0, bad_xs = 0, bad_dll = 0, a10_ok = 0;
    int nxt, ts_e, q_e, k_e;
    bit need = had_exit;
    logic [3:0] c;
    cfg_odt_lead = CW'(lead); cfg_trp = CW'(2); cfg_trfc = CW'(3);
    cfg_tcksre = CW'(sre); cfg_tckesr = CW'(esr); cfg_tcksrx = CW'(srx);
    cfg_txs = CW'(txs); cfg_txsdll = CW'(txsdll);
    banks_open = banks; sys_odt = 1'b1;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R3 odt low at first owned cycle", int'(odt), 0);
    chk("R2 bus_own after sleep", int'(bus_own), 1);
    chk("R2 ok flags low", int'(nondll_ok) + int'(dll_ok), 0);
    for (int t = 0; t < 600; t++) begin
      if (t > 0) @(negedge clk);
      c = cmdv();
      if (tf < 0 && c != 4'b0111) tf = t;
      if (tp < 0 && c == 4'b0010) begin tp = t; a10_ok = int'(cmd_a10); end
      if (tr < 0 && c == 4'b0001 && cke) tr = t;
      if (ts < 0 && c == 4'b0001 && !cke) begin
        ts = t;
        w_at = ts + 1 + w(sre) + w(sat(esr, sre)) + 2;
      end
      if (ts >= 0 && t == ts + 1 && (c != 4'b0111 || cke)) bad_sr++;
      if (ts >= 0 && t > ts && k < 0 && cke) k = t;
      if (tcs < 0 && clk_stop_ok) tcs = t;
      if (clk_stop_ok) clk_stable = 1'b0;
      if (tcs >= 0 && q < 0 && !clk_stop_ok) begin q = t; stab_at = t + dly; end
      if (t == stab_at) clk_stable = 1'b1;
      if (glitch && stab_at >= 0 && t == stab_at + 1) clk_stable = 1'b0;
      if (glitch && stab_at >= 0 && t == stab_at + 2) clk_stable = 1'b1;
      wake_req  = late ? (t == w_at) : (t == 0);
      sleep_req = (ts >= 0 && t == ts + 2); // R9: ignored while asleep
      if (k >= 0 && n < 0) begin
        if (nondll_ok) n = t;
        else if (c != 4'b0111 || !bus_own || odt) bad_xs++;
      end
      if (n >= 0 && d < 0 && dll_ok) d = t;
      if (n >= 0 && d < 0 && (odt || !cke)) bad_dll++;
      if (quick && n >= 0) break;
      if (!quick && d >= 0) break;
    end
    sleep_req = 1'b0; wake_req = 1'b0;
    chk("R3 first command delay", tf, w(lead));
    if (banks) begin
      chk("R4 precharge position", tp, w(lead));
      chk("R2 precharge a10", a10_ok, 1);
      nxt = tp + 1 + w(2);
    end else begin
      chk("R4 no precharge", tp, -1);
      nxt = w(lead);
    end
    if (need) begin
      chk("R5 refresh position", tr, nxt);
      ts_e = tr + 1 + w(3);
    end else begin
      chk("R5 no refresh", tr, -1);
      ts_e = nxt;
    end
    chk("R6 entry position", ts, ts_e);
    chk("R6 single nop with cke low", bad_sr, 0);
    chk("R7 clk_stop_ok rise", tcs, ts + 1 + w(sre));
    q_e = late ? w_at + 1 : ts + 1 + w(sre) + w(sat(esr, sre)) + 1;
    chk("R8 exit start", q, q_e);
    k_e = q + dly + 1 + w(srx) + (glitch ? 2 : 0);
    chk("R10 cke rise", k, k_e);
    chk("R8 residency", int'(k - ts >= esr), 1);
    chk("R11 nondll_ok rise", n, k + w(txs));
    chk("R11 exit window nop only", bad_xs, 0);
    chk("R12 window odt/cke", bad_dll, 0);
    if (!quick) chk("R12 dll_ok rise", d, n + w(sat(txsdll, txs)));
    had_exit = 1'b1;
  endtask

  initial begin
    n_run = 0; n_fail = 0; had_exit = 1'b0;
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; banks_open = 1'b0;
    sys_odt = 1'b0; clk_stable = 1'b1;
    cfg_odt_lead = '0; cfg_trp = '0; cfg_trfc = '0; cfg_tcksre = '0;
    cfg_tckesr = '0; cfg_tcksrx = '0; cfg_txs = '0; cfg_txsdll = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cke", int'(cke), 1);
    chk("R1 bus_own", int'(bus_own), 0);
    chk("R1 clk_stop_ok", int'(clk_stop_ok), 0);
    chk("R1 ok flags", int'(nondll_ok) + int'(dll_ok), 2);
    chk("R1 nop", int'(cmdv()), 7);
    chk("R1 odt follows low", int'(odt), 0);
    sys_odt = 1'b1; #1;
    chk("R1 odt follows high", int'(odt), 1);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 wake in idle ignored", int'(bus_own) + int'(!cke), 0);
    for (int i = 0; i < 32; i++) begin
      // R13: every fourth run re-enters from inside the DLL window
      do_run((i & 1) ? 2 : 0, i[1], i[2] ? 3 : 1, i[3] ? 7 : 2, i[4],
             1 + (i % 3), i % 2, (i % 5) == 0, 4, ((i % 3) == 1) ? 3 : 9,
             (i % 4) == 3);
    end
    repeat (12) @(negedge clk);
    chk("R1 back to idle", int'(dll_ok) + int'(cke), 2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule